// File: doc/BRIEF.md
# Sequential Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor, both `W` bits wide (32 by default). It produces a `W`-bit quotient and a `W`-bit remainder over several clock cycles and uses only one trial subtractor. The working state is a single double-width shift register plus one overflow bit. Quotient bits enter at the bottom of the register as it shifts left. There is no separate quotient register.

The register is shifted left once when the operands are loaded, so the loop needs exactly `W` iterations. In each iteration the divisor is subtracted from the upper half. A non-negative difference is kept and a 1 enters at the bottom. A negative difference leaves the upper half as it was and a 0 enters at the bottom. One final cycle shifts the upper part right by one, which gives the true remainder, and publishes the results.

A client raises `start` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse, after which the quotient, remainder and divide-by-zero flag are valid. They stay valid until the next `done`.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: An operation is accepted on a rising edge where `start` is 1 and `busy` is 0. `dividend` and `divisor` are sampled on that edge, and `busy` is 1 from the next cycle on.
- R3: `done` is high for exactly one cycle. It rises on the W+1-th rising edge after the accepting edge, which is the edge on which `busy` falls. `done` is never high while `busy` is high.
- R4: For a non-zero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, with both taken as unsigned. This holds for divisors with the most significant bit set.
- R5: For a zero divisor, `div_by_zero` is 1 together with `done`, `quotient` is all ones and `remainder` equals the dividend. For any non-zero divisor, `div_by_zero` is 0 with `done`.
- R6: A `start` raised while `busy` is 1 is ignored. The operation in flight completes with its own operands, and no extra `done` follows.
- R7: `quotient`, `remainder` and `div_by_zero` keep their values in every cycle that is not a `done` cycle, whatever the operand inputs do.
- R8: A `start` raised in the cycle where `done` is high is accepted. The next operation therefore begins W+2 cycles after the previous accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; honoured only while idle |
| dividend | input | W | Unsigned dividend, sampled on the accepting edge |
| divisor | input | W | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when results are published |
| quotient | output | W | Unsigned quotient, held until the next done |
| remainder | output | W | Unsigned remainder, held until the next done |
| div_by_zero | output | 1 | Set with done when the divisor was zero |

## Verification
The checker watches every cycle.
- It confirms that the handshake is legal: `done` never overlaps `busy`, lasts a single cycle, and ends a busy span of exactly W+1 cycles.
- It confirms that the published outputs hold still between completions.
- At each completion it checks the identity dividend = quotient × divisor + remainder with remainder below the divisor, against the operands it captured itself.
- It checks the zero-divisor result and confirms that the number of kept trial subtractions matches the ones in the quotient.

Only the bench's scenarios can show three behaviours:
- A request raised during an operation is really ignored.
- A request raised in the `done` cycle starts the next operation without a gap.
- Boundary operands give the exact expected values: all-ones dividends, divisors with the top bit set, divisors above the dividend, and zero divisors.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_trial_sub.sv
module div_trial_sub #(
  parameter int W = 32
) (
  input  logic [W:0]   upper,
  input  logic [W-1:0] dvsr,
  output logic         keep,
  output logic [W-1:0] next_hi
);
  localparam int SW = W + 1;

  // Trial difference; the partial remainder is below 2*dvsr, so W+1 bits
  // of two's complement always hold the true sign.
  function automatic logic [SW-1:0] trial_diff(input logic [SW-1:0] a,
                                               input logic [W-1:0]  d);
    return a - {1'b0, d};
  endfunction

  // Restore path: a negative trial means the top bit of upper was clear.
  function automatic logic [W-1:0] pick_hi(input logic          ok,
                                           input logic [SW-1:0] diff,
                                           input logic [SW-1:0] a);
    return ok ? diff[W-1:0] : a[W-1:0];
  endfunction

  logic [SW-1:0] diff;

  always_comb begin
    diff    = trial_diff(upper, dvsr);
    keep    = ~diff[SW-1];
    next_hi = pick_hi(keep, diff, upper);
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign load      = start && (st_q == ST_IDLE);
  assign step      = (st_q == ST_RUN);
  assign finish    = (st_q == ST_FIX);
  assign busy      = (st_q != ST_IDLE);
  assign last_step = step && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      case (st_q)
        ST_IDLE: begin
          if (load) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_step) st_q <= ST_FIX;
        end
        ST_FIX:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         finish,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         keep,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  localparam int AW = 2 * W + 1;   // overflow bit + upper half + lower half

  logic [AW-1:0] acc_q;
  logic [W-1:0]  dvsr_q;
  logic          zero_pend_q;
  logic [W-1:0]  next_hi;

  // Upper part including the bit pushed out by the previous left shift.
  function automatic logic [W:0] upper_of(input logic [AW-1:0] a);
    return a[AW-1:W];
  endfunction

  // The loop shifts once too often; dropping one bit restores the remainder.
  function automatic logic [W-1:0] fix_rem(input logic [AW-1:0] a);
    return a[AW-1:W+1];
  endfunction

  div_trial_sub #(.W(W)) u_trial (
    .upper   (upper_of(acc_q)),
    .dvsr    (dvsr_q),
    .keep    (keep),
    .next_hi (next_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      dvsr_q      <= '0;
      zero_pend_q <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      if (load) begin
        acc_q       <= {{W{1'b0}}, dividend, 1'b0};   // load with first shift
        dvsr_q      <= divisor;
        zero_pend_q <= (divisor == '0);
      end else if (step) begin
        acc_q <= {next_hi, acc_q[W-1:0], keep};
      end
      if (finish) begin
        quotient    <= acc_q[W-1:0];
        remainder   <= fix_rem(acc_q);
        div_by_zero <= zero_pend_q;
      end
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  logic evt_load;
  logic evt_step;
  logic evt_finish;
  logic evt_keep;

  div_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .load   (evt_load),
    .step   (evt_step),
    .finish (evt_finish),
    .busy   (busy),
    .done   (done)
  );

  div_datapath #(.W(W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (evt_load),
    .step        (evt_step),
    .finish      (evt_finish),
    .dividend    (dividend),
    .divisor     (divisor),
    .keep        (evt_keep),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
  );
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero,
  input logic         evt_step,
  input logic         evt_keep
);
  localparam int W2 = 2 * W;
  localparam int BW = $clog2(W + 4) + 1;
  localparam int KW = $clog2(W + 1) + 1;

  logic [W-1:0]  cap_dvd, cap_div;
  logic [BW-1:0] busy_cnt;
  logic [KW-1:0] keep_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dvd  <= '0;
      cap_div  <= '0;
      busy_cnt <= '0;
      keep_cnt <= '0;
    end else begin
      if (start && !busy) begin
        cap_dvd  <= dividend;
        cap_div  <= divisor;
        keep_cnt <= '0;
      end else if (evt_step && evt_keep) begin
        keep_cnt <= keep_cnt + 1'b1;
      end
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
    end
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && busy_cnt == BW'(W + 1)));

  // R4
  result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_div != '0) |->
      ((W2'(quotient) * W2'(cap_div) + W2'(remainder)) == W2'(cap_dvd)
       && remainder < cap_div));

  // R4
  keep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(quotient) == int'(keep_cnt)));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_by_zero == (cap_div == '0)));

  // R5
  zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_div == '0) |-> (quotient == '1 && remainder == cap_dvd));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .dividend    (dividend),
  .divisor     (divisor),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero),
  .evt_step    (evt_step),
  .evt_keep    (evt_keep)
);

// File: tb/seq_divider_tb.sv
module seq_divider_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int last_acc = 0;
  int dones_seen = 0;
  int pushes = 0;
  logic done_prev = 1'b0;

  logic [W-1:0] exp_q[$];
  logic [W-1:0] exp_r[$];
  logic         exp_z[$];
  int           acc_cyc[$];

  seq_divider #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    exp_q.push_back((b == '0) ? '1 : a / b);
    exp_r.push_back((b == '0) ? a : a % b);
    exp_z.push_back(b == '0);
    pushes++;
    @(posedge clk);
    #1;
    acc_cyc.push_back(cyc);
    last_acc = cyc;
    chk("R2 busy after accept", 64'(busy), 64'd1);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((exp_q.size() != 0 || busy) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && done_prev) begin
        n_chk++; n_err++;
        $display("FAIL R3: done high two cycles, actual=1 expected=0");
      end
      if (done) begin
        dones_seen++;
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R6: unexpected done, actual=1 expected=0");
        end else begin
          automatic logic [W-1:0] q = exp_q.pop_front();
          automatic logic [W-1:0] r = exp_r.pop_front();
          automatic logic         z = exp_z.pop_front();
          automatic int           a = acc_cyc.pop_front();
          chk(z ? "R5 quotient" : "R4 quotient", 64'(quotient), 64'(q));
          chk(z ? "R5 remainder" : "R4 remainder", 64'(remainder), 64'(r));
          chk("R5 flag", 64'(div_by_zero), 64'(z));
          chk("R3 latency", 64'(cyc - a), 64'(W + 1));
          chk("R3 busy low at done", 64'(busy), 64'd0);
        end
      end
    end
    done_prev = done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int first_acc;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 quotient", 64'(quotient), 64'd0);
    chk("R1 remainder", 64'(remainder), 64'd0);
    chk("R1 flag", 64'(div_by_zero), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_div(32'd7, 32'd2);
    wait_idle();
    // R7: outputs hold while inputs wander and no start
    dividend = 32'hDEAD_BEEF;
    divisor  = 32'h0000_0003;
    repeat (6) @(negedge clk);
    chk("R7 quotient held", 64'(quotient), 64'd3);
    chk("R7 remainder held", 64'(remainder), 64'd1);

    // R4 boundary operands
    run_div(32'd100, 32'd7);
    run_div(32'd0, 32'd5);
    run_div(32'd5, 32'd9);
    run_div(32'hFFFF_FFFF, 32'd1);
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_div(32'h8000_0000, 32'h8000_0001);
    run_div(32'hFFFF_FFFE, 32'h8000_0000);
    run_div(32'hFFFF_FFFF, 32'hC000_0001);
    run_div(32'h1234_5678, 32'h0000_1000);
    // R5 zero divisor
    run_div(32'h1234_5678, 32'd0);
    run_div(32'd0, 32'd0);
    run_div(32'd9, 32'd3);
    wait_idle();

    // R6: start while busy is ignored
    run_div(32'd1000, 32'd3);
    repeat (4) @(negedge clk);
    dividend = 32'd50;
    divisor  = 32'd5;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (W + 6) @(negedge clk);
    chk("R6 done count", 64'(dones_seen), 64'(pushes));
    chk("R6 quotient", 64'(quotient), 64'd333);

    // R8: back-to-back accept in done cycle
    run_div(32'd77, 32'd10);
    first_acc = last_acc;
    run_div(32'd78, 32'd11);
    chk("R8 accept gap", 64'(last_acc - first_acc), 64'(W + 2));
    wait_idle();

    // Mixed operands
    for (int i = 0; i < 24; i++) begin
      automatic logic [W-1:0] a = $urandom();
      automatic logic [W-1:0] b = $urandom() >> ($urandom() % 32);
      run_div(a, b);
    end
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R6 final done count", 64'(dones_seen), 64'(pushes));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule